// File: doc/BRIEF.md
# Arbitrated Single-Port FIFO

A single-clock first-in first-out buffer whose storage is one memory array with one port, so only one access can take place in any cycle. It suits traffic that arrives in bursts, where a producer streams a whole cell of data in and a consumer later streams it out, and the two sides rarely need the memory at the same time.

Each side raises a request and sees a ready signal. A push or pop takes effect in a cycle where its request and its ready are both high. When both sides ask for a usable access together, a build-time priority parameter chooses the winner and holds the loser's ready low for that cycle. A side that cannot proceed because the buffer is full or empty does not block the other side, whatever the priority. Popped data comes out one cycle after the grant, marked by a valid strobe.

Top module: `arb_fifo`

## Requirements
- R1: After reset the buffer is empty: `empty_o`=1, `full_o`=0, `pop_valid_o`=0.
- R2: A push grant (`push_i`&&`push_ready_o`) and a pop grant (`pop_i`&&`pop_ready_o`) are never high in the same cycle.
- R3: With `READ_FIRST`=0, when push and pop are both requested and the buffer is neither full nor empty, `push_ready_o`=1 and `pop_ready_o`=0.
- R4: With `READ_FIRST`=1, in the same situation, `pop_ready_o`=1 and `push_ready_o`=0.
- R5: When the buffer is full, a pop request is granted even if a push is requested; when it is empty, a push request is granted even if a pop is requested; this holds for both priority settings.
- R6: A pop granted in cycle k gives `pop_valid_o`=1 in cycle k+1 with `pop_data_o` equal to the oldest stored word; in every other cycle `pop_valid_o`=0. Words leave in the order they were accepted.
- R7: `full_o`=1 exactly when DEPTH words are stored; then `push_ready_o`=0 and a push request changes neither the count nor the stored words.
- R8: When the buffer is empty `pop_ready_o`=0, and a pop request produces no valid strobe.
- R9: A burst of 53 words can be pushed on 53 consecutive cycles and popped on 53 consecutive cycles, one word per cycle.
- R10: A stalled request is granted in the first cycle where no higher-priority usable request is pending and its own side is not blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request |
| push_data_i | input | DATA_W | Word to store |
| push_ready_o | output | 1 | Push would be accepted this cycle |
| pop_i | input | 1 | Pop request |
| pop_ready_o | output | 1 | Pop would be accepted this cycle |
| pop_data_o | output | DATA_W | Popped word, valid with pop_valid_o |
| pop_valid_o | output | 1 | Popped word present this cycle |
| full_o | output | 1 | DEPTH words stored |
| empty_o | output | 1 | No words stored |

## Verification
Push and pop requests can coincide in one cycle, and only one of them may reach the memory. The bench drives both requests together while the buffer is partly filled, while it is full and while it is empty, into two instances built with opposite priority, and judges from a count-based reference model which ready goes high and that the word order at the output stays intact. A reference queue per instance compares every popped word with the word accepted earliest.

// File: rtl/arb_fifo_pkg.sv
package arb_fifo_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_WR   = 2'd1,
    ACC_RD   = 2'd2
  } acc_e;
endpackage

// File: rtl/arb_fifo_arb.sv
module arb_fifo_arb
  import arb_fifo_pkg::*;
#(
  parameter bit READ_FIRST = 1'b0
) (
  input  logic push_i,
  input  logic pop_i,
  input  logic full_i,
  input  logic empty_i,
  output logic push_ready_o,
  output logic pop_ready_o,
  output acc_e acc_o
);

  generate
    if (READ_FIRST) begin : g_rd_first
      logic rd_usable;
      assign rd_usable    = pop_i && !empty_i;
      assign pop_ready_o  = !empty_i;
      assign push_ready_o = !full_i && !rd_usable;
    end else begin : g_wr_first
      logic wr_usable;
      assign wr_usable    = push_i && !full_i;
      assign push_ready_o = !full_i;
      assign pop_ready_o  = !empty_i && !wr_usable;
    end
  endgenerate

  always_comb begin
    acc_o = ACC_NONE;
    if (push_i && push_ready_o)     acc_o = ACC_WR;
    else if (pop_i && pop_ready_o)  acc_o = ACC_RD;
  end

endmodule

// File: rtl/arb_fifo_ptr.sv
module arb_fifo_ptr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_go_i,
  input  logic              rd_go_i,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              full_o,
  output logic              empty_o
);

  // extra MSB distinguishes full from empty
  logic [ADDR_W:0] wp_q, rp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (wr_go_i) wp_q <= wp_q + 1'b1;
      if (rd_go_i) rp_q <= rp_q + 1'b1;
    end
  end

  assign waddr_o = wp_q[ADDR_W-1:0];
  assign raddr_o = rp_q[ADDR_W-1:0];
  assign empty_o = (wp_q == rp_q);
  assign full_o  = (wp_q[ADDR_W] != rp_q[ADDR_W]) &&
                   (wp_q[ADDR_W-1:0] == rp_q[ADDR_W-1:0]);

endmodule

// File: rtl/arb_fifo_spram.sv
module arb_fifo_spram
  import arb_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_e              acc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              valid_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;
  logic              valid_q;

  // one port: write or read, never both
  always_ff @(posedge clk_i) begin
    if (acc_i == ACC_WR)      mem_q[addr_i] <= wdata_i;
    else if (acc_i == ACC_RD) rdata_q       <= mem_q[addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= (acc_i == ACC_RD);
  end

  assign rdata_o = rdata_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/arb_fifo.sv
module arb_fifo
  import arb_fifo_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 64,
  parameter bit READ_FIRST = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic              push_ready_o,
  input  logic              pop_i,
  output logic              pop_ready_o,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              pop_valid_o,
  output logic              full_o,
  output logic              empty_o
);

  localparam int ADDR_W = $clog2(DEPTH);

  acc_e              acc;
  logic [ADDR_W-1:0] waddr, raddr, addr;
  logic              full, empty;

  arb_fifo_arb #(.READ_FIRST(READ_FIRST)) u_arb (
    .push_i       (push_i),
    .pop_i        (pop_i),
    .full_i       (full),
    .empty_i      (empty),
    .push_ready_o (push_ready_o),
    .pop_ready_o  (pop_ready_o),
    .acc_o        (acc)
  );

  arb_fifo_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_go_i (acc == ACC_WR),
    .rd_go_i (acc == ACC_RD),
    .waddr_o (waddr),
    .raddr_o (raddr),
    .full_o  (full),
    .empty_o (empty)
  );

  assign addr = (acc == ACC_RD) ? raddr : waddr;

  arb_fifo_spram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc),
    .addr_i  (addr),
    .wdata_i (push_data_i),
    .rdata_o (pop_data_o),
    .valid_o (pop_valid_o)
  );

  assign full_o  = full;
  assign empty_o = empty;

endmodule

// File: rtl/arb_fifo_chk.sv
module arb_fifo_chk #(
  parameter bit READ_FIRST = 1'b0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic push_i,
  input logic push_ready_o,
  input logic pop_i,
  input logic pop_ready_o,
  input logic pop_valid_o,
  input logic full_o,
  input logic empty_o
);

  logic wr_go, rd_go;
  assign wr_go = push_i && push_ready_o;
  assign rd_go = pop_i && pop_ready_o;

  p_one_access_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_go && rd_go));

  p_not_both_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  p_prio_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!READ_FIRST && push_i && pop_i && !full_o && !empty_o) |-> (wr_go && !pop_ready_o));

  p_prio_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (READ_FIRST && push_i && pop_i && !full_o && !empty_o) |-> (rd_go && !push_ready_o));

  p_full_pop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && pop_i) |-> rd_go);

  p_empty_push_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && push_i) |-> wr_go);

  p_valid_after_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_go |=> pop_valid_o);

  p_no_stray_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_go |=> !pop_valid_o);

  p_full_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_ready_o);

  p_full_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !rd_go) |=> full_o);

  p_empty_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_ready_o);

  p_empty_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !wr_go) |=> empty_o);

endmodule

bind arb_fifo arb_fifo_chk #(.READ_FIRST(READ_FIRST)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .push_i       (push_i),
  .push_ready_o (push_ready_o),
  .pop_i        (pop_i),
  .pop_ready_o  (pop_ready_o),
  .pop_valid_o  (pop_valid_o),
  .full_o       (full_o),
  .empty_o      (empty_o)
);

// File: tb/arb_fifo_tb.sv
`timescale 1ns/1ps
module arb_fifo_tb;
  localparam int DW = 8;
  localparam int DEP = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push = 1'b0, pop = 1'b0;
  logic [DW-1:0] din = '0;
  logic [1:0] prdy, ordy, vld, full, empty;
  logic [DW-1:0] rdata [2];

  int total = 0, bad = 0;
  int cnt [2];
  logic [DW-1:0] mq [2][$];
  logic pend [2];
  logic [DW-1:0] pend_d [2];
  int burst_vld = 0;
  bit in_burst = 0;

  always #2 clk = ~clk;

  arb_fifo #(.DATA_W(DW), .DEPTH(DEP), .READ_FIRST(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(din),
    .push_ready_o(prdy[0]), .pop_i(pop), .pop_ready_o(ordy[0]),
    .pop_data_o(rdata[0]), .pop_valid_o(vld[0]), .full_o(full[0]), .empty_o(empty[0]));

  arb_fifo #(.DATA_W(DW), .DEPTH(DEP), .READ_FIRST(1'b1)) u_dut_rf (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(din),
    .push_ready_o(prdy[1]), .pop_i(pop), .pop_ready_o(ordy[1]),
    .pop_data_o(rdata[1]), .pop_valid_o(vld[1]), .full_o(full[1]), .empty_o(empty[1]));

  task automatic check(input string tag, input int s, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s inst%0d t=%0t actual=%0d expected=%0d", tag, s, $time, act, exp);
    end
  endtask

  task automatic model(input int s);
    logic ef, ee, wok, rok, epr, eor;
    string tag;
    ef = (cnt[s] == DEP);
    ee = (cnt[s] == 0);
    wok = push && !ef;
    rok = pop && !ee;
    if (s == 1) begin eor = !ee; epr = !ef && !rok; end
    else        begin epr = !ef; eor = !ee && !wok; end
    if (push && pop && !ef && !ee) tag = (s == 1) ? "R4" : "R3";
    else if (push && pop)          tag = "R5";
    else if (ef)                   tag = "R7";
    else if (ee)                   tag = "R8";
    else                           tag = "R10";
    check(tag, s, full[s], ef);
    check(tag, s, empty[s], ee);
    check(tag, s, prdy[s], epr);
    check(tag, s, ordy[s], eor);
    check("R2", s, (push && prdy[s] && pop && ordy[s]) ? 1 : 0, 0);
    check("R6", s, vld[s], pend[s]);
    if (pend[s]) check("R6", s, rdata[s], pend_d[s]);
    if (s == 0 && in_burst && vld[0]) burst_vld++;
    pend[s] = 1'b0;
    if (push && epr) begin mq[s].push_back(din); cnt[s]++; end
    if (pop && eor) begin pend[s] = 1'b1; pend_d[s] = mq[s].pop_front(); cnt[s]--; end
  endtask

  always @(negedge clk) if (rst_n) begin
    model(0);
    model(1);
  end

  task automatic drive(input logic pu, input logic po, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      push = pu; pop = po; din = din + 8'd1;
    end
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int s = 0; s < 2; s++) begin cnt[s] = 0; pend[s] = 1'b0; pend_d[s] = '0; end
    repeat (3) @(posedge clk);
    #1;
    for (int s = 0; s < 2; s++) begin   // R1 reset state
      check("R1", s, empty[s], 1);
      check("R1", s, full[s], 0);
      check("R1", s, vld[s], 0);
    end
    rst_n = 1'b1;
    // R9 burst of 53 in, 53 out
    drive(1, 0, 53);
    @(posedge clk); #1; push = 0; pop = 1; in_burst = 1;
    drive(0, 1, 52);
    drive(0, 0, 3);
    in_burst = 0;
    check("R9", 0, burst_vld, 53);
    // R3/R4 contention at mid level
    drive(1, 0, 10);
    drive(1, 1, 20);
    drive(0, 1, 40);
    // R7 fill past full, R5 contention while full
    drive(1, 0, 75);
    drive(1, 1, 5);
    drive(0, 1, 75);   // R8 pops on empty
    drive(1, 1, 5);    // R5 contention while empty
    drive(0, 1, 10);
    // R10 mixed traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0] | lfsr[3], lfsr[1] & ~lfsr[5], 1);
    end
    drive(0, 1, 70);
    drive(0, 0, 3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule